// File: doc/BRIEF.md
# Soft-Ramped Stereo Volume Stage

This block scales a stereo stream of 24-bit two's-complement samples by a per-channel 8-bit linear gain code, where code N means a gain of N/255 and code 0 silences the channel. One left and one right sample arrive together, qualified by a single-cycle frame strobe. The scaled pair appears one clock later with a valid pulse.

The gain in use (the applied level) never jumps to a new setting. On each frame it moves one code toward its goal when a per-channel frame counter expires. The counter period depends on the sampling-speed mode: 4 frames in normal speed and in the one-bit stream mode, 8 in double speed, 16 in quad speed. The goal is the channel's target code. While soft mute is asserted the goal is zero instead. Releasing mute part way down turns the ramp around at the same slope. Both applied levels are visible at the ports, so a controller can tell when a ramp has finished.

Top module: `soft_gain_stage`

## Requirements
- R1: On a clock edge with `frame_stb` high, each output register loads the input sample times the applied level before that edge, divided by 255 and truncated toward zero (for example -5 at code 0x80 gives -2). `out_valid` is high exactly in the cycle after each strobe.
- R2: While `rst` is high, each applied level is loaded with its channel's target code and the step counters clear. Right after reset, with targets held at 0xFF, both levels read 0xFF and the outputs read zero.
- R3: With `spd_mode` = 00 (normal), 01 (double) or 10 (quad), the applied level moves by exactly one code after 4, 8 or 16 strobes respectively while it differs from its goal.
- R4: A ramp from 255 to 0, or from 0 to 255, takes 1020 strobes in normal speed, 2040 in double and 4080 in quad.
- R5: While `mute_req` is high the goal is zero: the level falls to 0 at the step rate and never rises.
- R6: When `mute_req` drops before the level reaches zero, the level turns around from its current value and climbs to the target at the same rate.
- R7: `spd_mode` = 11 (one-bit stream) steps every 4 strobes. A change of `spd_mode` leaves the applied levels untouched.
- R8: The applied level changes only on a strobe edge and by at most one code per edge.
- R9: An applied level of 0 drives that channel's output to zero.
- R10: The two channels ramp and scale independently of each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | One-cycle strobe marking a new sample pair |
| spd_mode | input | 2 | 00 normal, 01 double, 10 quad, 11 one-bit stream |
| mute_req | input | 1 | Soft-mute request, applied to both channels |
| tgt_lvl_l | input | 8 | Left target gain code |
| tgt_lvl_r | input | 8 | Right target gain code |
| smp_in_l | input | 24 | Left input sample, two's complement |
| smp_in_r | input | 24 | Right input sample, two's complement |
| smp_out_l | output | 24 | Left scaled sample |
| smp_out_r | output | 24 | Right scaled sample |
| out_valid | output | 1 | High in the cycle after a strobe |
| cur_lvl_l | output | 8 | Left applied gain code |
| cur_lvl_r | output | 8 | Right applied gain code |

## Verification
The properties assume that `frame_stb` is a single-cycle pulse and that the targets, mode and mute inputs change only between strobes. Under that assumption a level that stays put on non-strobe cycles, or moves by one code at most, is a sign of correct design. The stimulus always spaces strobes three clocks apart and changes control inputs only in the idle cycles. A reference model in the bench tracks the expected level and counter per channel, so every strobe's output pair and levels are compared against it. That includes strobes that fall mid-ramp, across mode switches and around a mute reversal.

// File: rtl/sgain_pkg.sv
package sgain_pkg;

    localparam int DEF_SMP_W     = 24;
    localparam int DEF_LVL_W     = 8;
    localparam int DEF_BASE_STEP = 4;

    typedef enum logic [1:0] {
        SPD_NORMAL    = 2'b00,
        SPD_DOUBLE    = 2'b01,
        SPD_QUAD      = 2'b10,
        SPD_BITSTREAM = 2'b11
    } spd_e;

    typedef enum logic [1:0] {
        SLEW_HOLD,
        SLEW_UP,
        SLEW_DOWN
    } slew_dir_e;

    // Frames per level step for a given speed mode.
    function automatic int step_frames(input logic [1:0] mode, input int base);
        case (spd_e'(mode))
            SPD_DOUBLE: return base * 2;
            SPD_QUAD:   return base * 4;
            default:    return base;
        endcase
    endfunction

endpackage

// File: rtl/sgain_slew.sv
module sgain_slew
    import sgain_pkg::*;
#(
    parameter int LVL_W     = DEF_LVL_W,
    parameter int BASE_STEP = DEF_BASE_STEP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic [1:0]       mode,
    input  logic             mute,
    input  logic [LVL_W-1:0] tgt,
    output logic [LVL_W-1:0] lvl
);

    localparam int CW = $clog2(BASE_STEP * 4);

    logic [CW-1:0]    cnt_q;
    logic [CW-1:0]    last_cnt;
    logic [LVL_W-1:0] lvl_q;
    logic [LVL_W-1:0] goal;
    slew_dir_e        dir;

    always_comb begin
        goal     = mute ? '0 : tgt;
        last_cnt = CW'(step_frames(mode, BASE_STEP) - 1);
        if (lvl_q == goal)     dir = SLEW_HOLD;
        else if (lvl_q < goal) dir = SLEW_UP;
        else                   dir = SLEW_DOWN;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= tgt;
            cnt_q <= '0;
        end else if (stb) begin
            if (dir == SLEW_HOLD) begin
                cnt_q <= '0;
            end else if (cnt_q == last_cnt) begin
                cnt_q <= '0;
                lvl_q <= (dir == SLEW_UP) ? lvl_q + 1'b1 : lvl_q - 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign lvl = lvl_q;

endmodule

// File: rtl/sgain_scaler.sv
module sgain_scaler
    import sgain_pkg::*;
#(
    parameter int SMP_W = DEF_SMP_W,
    parameter int LVL_W = DEF_LVL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stb,
    input  logic [SMP_W-1:0] smp_in,
    input  logic [LVL_W-1:0] lvl,
    output logic [SMP_W-1:0] smp_out
);

    localparam int PW   = SMP_W + LVL_W + 1;
    localparam int FULL = (1 << LVL_W) - 1;
    localparam logic signed [PW-1:0] DIVR = PW'(FULL);
    localparam logic signed [PW-1:0] MAXP = PW'((longint'(1) << (SMP_W - 1)) - 1);
    localparam logic signed [PW-1:0] MINN = -MAXP - PW'(1);

    logic signed [PW-1:0] prod;
    logic signed [PW-1:0] quot;
    logic [SMP_W-1:0]     sat;

    always_comb begin
        prod = PW'($signed(smp_in)) * PW'($signed({1'b0, lvl}));
        quot = prod / DIVR;
        if (quot > MAXP)      sat = MAXP[SMP_W-1:0];
        else if (quot < MINN) sat = MINN[SMP_W-1:0];
        else                  sat = quot[SMP_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)      smp_out <= '0;
        else if (stb) smp_out <= sat;
    end

endmodule

// File: rtl/soft_gain_stage.sv
module soft_gain_stage
    import sgain_pkg::*;
#(
    parameter int SMP_W     = DEF_SMP_W,
    parameter int LVL_W     = DEF_LVL_W,
    parameter int BASE_STEP = DEF_BASE_STEP
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_stb,
    input  logic [1:0]       spd_mode,
    input  logic             mute_req,
    input  logic [LVL_W-1:0] tgt_lvl_l,
    input  logic [LVL_W-1:0] tgt_lvl_r,
    input  logic [SMP_W-1:0] smp_in_l,
    input  logic [SMP_W-1:0] smp_in_r,
    output logic [SMP_W-1:0] smp_out_l,
    output logic [SMP_W-1:0] smp_out_r,
    output logic             out_valid,
    output logic [LVL_W-1:0] cur_lvl_l,
    output logic [LVL_W-1:0] cur_lvl_r
);

    localparam int NCH = 2;

    logic [LVL_W-1:0] tgt_a [NCH];
    logic [LVL_W-1:0] lvl_a [NCH];
    logic [SMP_W-1:0] in_a  [NCH];
    logic [SMP_W-1:0] out_a [NCH];

    assign tgt_a[0] = tgt_lvl_l;
    assign tgt_a[1] = tgt_lvl_r;
    assign in_a[0]  = smp_in_l;
    assign in_a[1]  = smp_in_r;

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        sgain_slew #(
            .LVL_W     (LVL_W),
            .BASE_STEP (BASE_STEP)
        ) slew_i (
            .clk  (clk),
            .rst  (rst),
            .stb  (frame_stb),
            .mode (spd_mode),
            .mute (mute_req),
            .tgt  (tgt_a[ch]),
            .lvl  (lvl_a[ch])
        );

        sgain_scaler #(
            .SMP_W (SMP_W),
            .LVL_W (LVL_W)
        ) scale_i (
            .clk     (clk),
            .rst     (rst),
            .stb     (frame_stb),
            .smp_in  (in_a[ch]),
            .lvl     (lvl_a[ch]),
            .smp_out (out_a[ch])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) out_valid <= 1'b0;
        else     out_valid <= frame_stb;
    end

    assign smp_out_l = out_a[0];
    assign smp_out_r = out_a[1];
    assign cur_lvl_l = lvl_a[0];
    assign cur_lvl_r = lvl_a[1];

endmodule

// File: rtl/sgain_checker.sv
module sgain_checker #(
    parameter int SMP_W = 24,
    parameter int LVL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             frame_stb,
    input logic             mute_req,
    input logic [SMP_W-1:0] smp_out_l,
    input logic [SMP_W-1:0] smp_out_r,
    input logic             out_valid,
    input logic [LVL_W-1:0] cur_lvl_l,
    input logic [LVL_W-1:0] cur_lvl_r
);

    // R8
    quiet_lvl_l_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(cur_lvl_l));

    // R8
    quiet_lvl_r_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> $stable(cur_lvl_r));

    // R8
    unit_step_l_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((cur_lvl_l >= $past(cur_lvl_l)) ?
                         (cur_lvl_l - $past(cur_lvl_l)) :
                         ($past(cur_lvl_l) - cur_lvl_l)) <= 1);

    // R5
    mute_no_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && mute_req) |=>
            (cur_lvl_l <= $past(cur_lvl_l)) && (cur_lvl_r <= $past(cur_lvl_r)));

    // R9
    zero_gain_out_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && cur_lvl_l == '0) |=> smp_out_l == '0);

    // R1
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        frame_stb |=> out_valid);

    // R1
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !frame_stb |=> !out_valid);

    // R9
    zero_gain_out_r_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_stb && cur_lvl_r == '0) |=> smp_out_r == '0);

endmodule

bind soft_gain_stage sgain_checker #(
    .SMP_W (SMP_W),
    .LVL_W (LVL_W)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .frame_stb (frame_stb),
    .mute_req  (mute_req),
    .smp_out_l (smp_out_l),
    .smp_out_r (smp_out_r),
    .out_valid (out_valid),
    .cur_lvl_l (cur_lvl_l),
    .cur_lvl_r (cur_lvl_r)
);

// File: tb/soft_gain_stage_tb_top.sv
module soft_gain_stage_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        frame_stb = 1'b0;
    logic [1:0]  spd_mode = 2'b00;
    logic        mute_req = 1'b0;
    logic [7:0]  tgt_lvl_l = 8'hFF;
    logic [7:0]  tgt_lvl_r = 8'hFF;
    logic [23:0] smp_in_l = '0;
    logic [23:0] smp_in_r = '0;
    logic [23:0] smp_out_l;
    logic [23:0] smp_out_r;
    logic        out_valid;
    logic [7:0]  cur_lvl_l;
    logic [7:0]  cur_lvl_r;

    always #2 clk = ~clk;

    soft_gain_stage dut_i (
        .clk       (clk),
        .rst       (rst),
        .frame_stb (frame_stb),
        .spd_mode  (spd_mode),
        .mute_req  (mute_req),
        .tgt_lvl_l (tgt_lvl_l),
        .tgt_lvl_r (tgt_lvl_r),
        .smp_in_l  (smp_in_l),
        .smp_in_r  (smp_in_r),
        .smp_out_l (smp_out_l),
        .smp_out_r (smp_out_r),
        .out_valid (out_valid),
        .cur_lvl_l (cur_lvl_l),
        .cur_lvl_r (cur_lvl_r)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference model state
    int mdl_lvl [2];
    int mdl_cnt [2];

    // scoreboard queues
    logic [23:0] exp_ol_q [$];
    logic [23:0] exp_or_q [$];
    logic [7:0]  exp_ll_q [$];
    logic [7:0]  exp_lr_q [$];
    string       tag_q    [$];

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] ref_scale(input logic [23:0] s, input int lvl);
        longint p;
        p = longint'($signed(s)) * longint'(lvl);
        return 24'(p / 255);
    endfunction

    function automatic int ref_period(input logic [1:0] m);
        case (m)
            2'b01:   return 8;
            2'b10:   return 16;
            default: return 4;
        endcase
    endfunction

    task automatic mdl_step();
        int per;
        int goal;
        per = ref_period(spd_mode);
        for (int ch = 0; ch < 2; ch++) begin
            goal = mute_req ? 0 : ((ch == 0) ? int'(tgt_lvl_l) : int'(tgt_lvl_r));
            if (mdl_lvl[ch] == goal) begin
                mdl_cnt[ch] = 0;
            end else if (mdl_cnt[ch] == per - 1) begin
                mdl_cnt[ch] = 0;
                mdl_lvl[ch] += (mdl_lvl[ch] < goal) ? 1 : -1;
            end else begin
                mdl_cnt[ch]++;
            end
        end
    endtask

    // driver: one frame, three clocks long
    task automatic frame(input logic [23:0] l, input logic [23:0] r, input string tag);
        @(negedge clk);
        smp_in_l  = l;
        smp_in_r  = r;
        frame_stb = 1'b1;
        exp_ol_q.push_back(ref_scale(l, mdl_lvl[0]));
        exp_or_q.push_back(ref_scale(r, mdl_lvl[1]));
        mdl_step();
        exp_ll_q.push_back(8'(mdl_lvl[0]));
        exp_lr_q.push_back(8'(mdl_lvl[1]));
        tag_q.push_back(tag);
        @(negedge clk);
        frame_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        mdl_lvl[0] = int'(tgt_lvl_l);
        mdl_lvl[1] = int'(tgt_lvl_r);
        mdl_cnt[0] = 0;
        mdl_cnt[1] = 0;
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            if (exp_ol_q.size() == 0) begin
                chk(1'b0, "R1 unexpected out_valid", 1, 0);
            end else begin
                logic [23:0] eol, eor;
                logic [7:0]  ell, elr;
                string       t;
                eol = exp_ol_q.pop_front();
                eor = exp_or_q.pop_front();
                ell = exp_ll_q.pop_front();
                elr = exp_lr_q.pop_front();
                t   = tag_q.pop_front();
                chk(smp_out_l == eol, {t, " R1 left out"}, longint'($signed(smp_out_l)), longint'($signed(eol)));
                chk(smp_out_r == eor, {t, " R10 right out"}, longint'($signed(smp_out_r)), longint'($signed(eor)));
                chk(cur_lvl_l == ell, {t, " R8 left lvl"}, cur_lvl_l, ell);
                chk(cur_lvl_r == elr, {t, " R10 right lvl"}, cur_lvl_r, elr);
            end
        end
    end

    task automatic ramp_until(input int goal_l, input int limit, output int frames);
        frames = 0;
        while (int'(cur_lvl_l) != goal_l && frames < limit) begin
            frame(24'h123456, 24'hFEDCBA, "R4 ramp");
            frames++;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        do_reset();

        // R2: reset state
        @(negedge clk);
        chk(cur_lvl_l == 8'hFF, "R2 reset lvl l", cur_lvl_l, 255);
        chk(cur_lvl_r == 8'hFF, "R2 reset lvl r", cur_lvl_r, 255);
        chk(smp_out_l == '0 && out_valid == 1'b0, "R2 reset outputs", smp_out_l, 0);

        // R1: unity gain passes samples unchanged
        frame(24'h123456, 24'hEDCBAA, "R1 unity a");
        frame(24'h7FFFFF, 24'h800000, "R1 unity extremes");
        frame(24'h000000, 24'hFFFFFF, "R1 unity small");

        // R1: out_valid timing around a manual strobe
        @(negedge clk);
        smp_in_l  = 24'h000010;
        smp_in_r  = 24'h000020;
        frame_stb = 1'b1;
        exp_ol_q.push_back(ref_scale(24'h000010, mdl_lvl[0]));
        exp_or_q.push_back(ref_scale(24'h000020, mdl_lvl[1]));
        mdl_step();
        exp_ll_q.push_back(8'(mdl_lvl[0]));
        exp_lr_q.push_back(8'(mdl_lvl[1]));
        tag_q.push_back("R1 manual");
        @(negedge clk);
        frame_stb = 1'b0;
        chk(out_valid == 1'b1, "R1 valid after strobe", out_valid, 1);
        @(negedge clk);
        chk(out_valid == 1'b0, "R1 valid drops", out_valid, 0);

        // R3: step periods per mode, R10: right stays put
        tgt_lvl_l = 8'hF0;
        repeat (3) frame(24'h200000, 24'h200000, "R3 normal");
        chk(cur_lvl_l == 8'hFF, "R3 no step before 4 frames", cur_lvl_l, 255);
        frame(24'h200000, 24'h200000, "R3 normal");
        chk(cur_lvl_l == 8'hFE, "R3 step at 4 frames", cur_lvl_l, 254);
        spd_mode = 2'b01;
        repeat (8) frame(24'h200000, 24'h200000, "R3 double");
        chk(cur_lvl_l == 8'hFD, "R3 step at 8 frames", cur_lvl_l, 253);
        spd_mode = 2'b10;
        repeat (16) frame(24'h200000, 24'h200000, "R3 quad");
        chk(cur_lvl_l == 8'hFC, "R3 step at 16 frames", cur_lvl_l, 252);
        chk(cur_lvl_r == 8'hFF, "R10 right untouched", cur_lvl_r, 255);

        // R4, R5: full ramps in each speed
        tgt_lvl_l = 8'hFF;
        spd_mode  = 2'b00;
        do_reset();
        mute_req = 1'b1;
        ramp_until(0, 5000, n);
        chk(n == 1020, "R4 normal full ramp down", n, 1020);
        chk(cur_lvl_r == 8'h00, "R5 right muted", cur_lvl_r, 0);
        frame(24'h7FFFFF, 24'h800000, "R9 muted output");
        spd_mode = 2'b01;
        mute_req = 1'b0;
        ramp_until(255, 5000, n);
        chk(n == 2040, "R4 double full ramp up", n, 2040);
        spd_mode = 2'b10;
        mute_req = 1'b1;
        ramp_until(0, 5000, n);
        chk(n == 4080, "R4 quad full ramp down", n, 4080);

        // R6: mute released mid-ramp turns around
        mute_req = 1'b0;
        spd_mode = 2'b00;
        do_reset();
        mute_req = 1'b1;
        repeat (40) frame(24'h300000, 24'hD00000, "R6 down");
        chk(cur_lvl_l == 8'hF5, "R6 level before release", cur_lvl_l, 245);
        mute_req = 1'b0;
        repeat (4) frame(24'h300000, 24'hD00000, "R6 up");
        chk(cur_lvl_l == 8'hF6, "R6 first step up", cur_lvl_l, 246);
        repeat (16) frame(24'h300000, 24'hD00000, "R6 up");
        chk(cur_lvl_l == 8'hFA, "R6 climbing at same rate", cur_lvl_l, 250);
        repeat (24) frame(24'h300000, 24'hD00000, "R6 up");
        chk(cur_lvl_l == 8'hFF, "R6 back at target", cur_lvl_l, 255);

        // R7: bitstream mode keeps levels and steps every 4 frames
        spd_mode = 2'b11;
        repeat (5) frame(24'h010000, 24'h020000, "R7 hold");
        chk(cur_lvl_l == 8'hFF && cur_lvl_r == 8'hFF, "R7 level kept over mode change", cur_lvl_l, 255);
        tgt_lvl_l = 8'h40;
        tgt_lvl_r = 8'h40;
        repeat (8) frame(24'h010000, 24'h020000, "R7 ramp");
        chk(cur_lvl_l == 8'hFD, "R7 4-frame step", cur_lvl_l, 253);

        // R2: reset mid-ramp loads target at once
        do_reset();
        @(negedge clk);
        chk(cur_lvl_l == 8'h40 && cur_lvl_r == 8'h40, "R2 reset loads target", cur_lvl_l, 64);

        // R1 rounding, R9 zero gain, R10 independent channels
        tgt_lvl_l = 8'h80;
        tgt_lvl_r = 8'h00;
        spd_mode  = 2'b00;
        do_reset();
        frame(24'hFFFFFB, 24'h000005, "R1 rounding");
        chk($signed(smp_out_l) == -24'sd2, "R1 truncation toward zero", longint'($signed(smp_out_l)), -2);
        chk(smp_out_r == '0, "R9 zero code output", smp_out_r, 0);
        frame(24'h7FFFFF, 24'h7FFFFF, "R1 half gain max");
        frame(24'h800000, 24'h800000, "R1 half gain min");

        repeat (3) @(negedge clk);
        chk(exp_ol_q.size() == 0, "R1 all results seen", exp_ol_q.size(), 0);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule